// File: doc/BRIEF.md
# Hall Commutation and PWM Gating Logic

This block converts the three rotor-position sensor signals of a three-phase brushless motor into six registered switch commands, one high-side and one low-side per phase. The sensors use 120-degree encoding, so exactly one or two of the three signals are high at any time. A direction input selects the forward or reverse commutation order. Brake, coast and undervoltage inputs override normal drive in a fixed priority.

A chopping request from the PWM comparator and a trip from the over-current comparator arrive as digital pulses. Each one is caught in a latch that the oscillator's cycle-start pulse clears, so a request that arrives mid-cycle turns the switches off for the rest of that cycle. A quadrant-select input chooses what the chopping acts on. In two-quadrant mode it acts on the conducting low-side switch only. In four-quadrant mode it acts on both conducting switches.

The sensor inputs are asynchronous and pass through a synchronizer. All other inputs are taken as synchronous to `clk`.

Top module: `hall_commutator`

## Requirements
- R1: With `dir_i`=1, the sensor code {A,B,C} selects the active switch pair as follows: 101 gives A-high with B-low, 100 gives A-high with C-low, 110 gives B-high with C-low, 010 gives B-high with A-low, 011 gives C-high with A-low, and 001 gives C-high with B-low.
- R2: With `dir_i`=0, every code selects the R1 pair with the high and low phases exchanged. For example, 101 gives B-high with A-low.
- R3: Codes 000 and 111 turn all six outputs off.
- R4: `coast_i`=1 turns all six outputs off, whatever the brake, direction, quadrant and sensor inputs are.
- R5: With `brake_i`=1 and coast and undervoltage inactive, all high-side outputs are off and all low-side outputs are on.
- R6: During brake, a set chopping latch (PWM or over-current) turns all low-side outputs off.
- R7: `uv_i`=1 turns all six outputs off, whatever the other inputs are.
- R8: With `quad_sel_i`=0 in normal drive, a set chopping latch turns off the active low-side output and leaves the active high-side output on.
- R9: With `quad_sel_i`=1 in normal drive, a set chopping latch turns off both the active high-side and the active low-side outputs.
- R10: A one-cycle pulse on `pwm_off_i` or `oc_trip_i` sets its latch, which holds until a `cyc_start_i` pulse clears it. A request in the same cycle as `cyc_start_i` leaves the latch set.
- R11: A sensor change reaches the outputs on the third rising edge after it is applied. A change on brake, coast, direction, quadrant or undervoltage reaches them on the first edge. A chopping pulse reaches them on the second edge.
- R12: No phase ever has its high-side and low-side outputs on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_a_i | input | 1 | Phase A position sensor (asynchronous) |
| hall_b_i | input | 1 | Phase B position sensor (asynchronous) |
| hall_c_i | input | 1 | Phase C position sensor (asynchronous) |
| dir_i | input | 1 | Commutation order: 1 forward, 0 reverse |
| brake_i | input | 1 | Brake request |
| coast_i | input | 1 | Coast request, highest priority with undervoltage |
| quad_sel_i | input | 1 | 0: chop low side only, 1: chop both sides |
| oc_trip_i | input | 1 | Over-current comparator trip |
| pwm_off_i | input | 1 | PWM comparator off request |
| cyc_start_i | input | 1 | One-cycle pulse at each oscillator cycle start |
| uv_i | input | 1 | Undervoltage flag |
| hi_a_o | output | 1 | Phase A high-side command |
| hi_b_o | output | 1 | Phase B high-side command |
| hi_c_o | output | 1 | Phase C high-side command |
| lo_a_o | output | 1 | Phase A low-side command |
| lo_b_o | output | 1 | Phase B low-side command |
| lo_c_o | output | 1 | Phase C low-side command |

## Verification
The latch assertions treat `cyc_start_i` as a clear that can coincide with a request, and they hold in either case. The output assertions assume nothing about the sensor code, so invalid codes are covered as well. The stimulus holds each sensor code and each control setting for several cycles, longer than the three-edge sensor path. Chopping and cycle-start requests are one-cycle pulses driven on the falling edge, with one test that applies both in the same cycle.

// File: rtl/hcm_pkg.sv
package hcm_pkg;

  localparam int NUM_PHASES = 3;

  // bit 0 = phase A, bit 1 = phase B, bit 2 = phase C
  typedef logic [NUM_PHASES-1:0] phase_vec_t;

  typedef struct packed {
    phase_vec_t hi;
    phase_vec_t lo;
  } drive_t;

  localparam phase_vec_t PH_A    = 3'b001;
  localparam phase_vec_t PH_B    = 3'b010;
  localparam phase_vec_t PH_C    = 3'b100;
  localparam phase_vec_t PH_NONE = 3'b000;
  localparam phase_vec_t PH_ALL  = 3'b111;

endpackage

// File: rtl/hcm_sync.sv
module hcm_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[LAST];

endmodule

// File: rtl/hcm_cycle_latch.sv
module hcm_cycle_latch #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] hold_d;
  logic [WIDTH-1:0] hold_q;

  // a request outranks the cycle-start clear in the same cycle
  always_comb begin
    hold_d = hold_q;
    if (clr_i) begin
      hold_d = '0;
    end
    hold_d = hold_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign q_o = hold_q;

  AST_LATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i))) else $error("latch set lost"); // R10

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((q_o & $past(q_o)) == $past(q_o))) else $error("latch dropped without clear"); // R10

  AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i == '0) |=> (q_o == '0)) else $error("latch not cleared"); // R10

endmodule

// File: rtl/hcm_decode.sv
module hcm_decode
  import hcm_pkg::*;
(
  input  logic [2:0] code_i,   // {A,B,C}
  input  logic       dir_i,
  output drive_t     drive_o,
  output logic       valid_o
);

  phase_vec_t fwd_hi;
  phase_vec_t fwd_lo;

  always_comb begin
    fwd_hi  = PH_NONE;
    fwd_lo  = PH_NONE;
    valid_o = 1'b1;
    unique case (code_i)
      3'b101: begin fwd_hi = PH_A; fwd_lo = PH_B; end
      3'b100: begin fwd_hi = PH_A; fwd_lo = PH_C; end
      3'b110: begin fwd_hi = PH_B; fwd_lo = PH_C; end
      3'b010: begin fwd_hi = PH_B; fwd_lo = PH_A; end
      3'b011: begin fwd_hi = PH_C; fwd_lo = PH_A; end
      3'b001: begin fwd_hi = PH_C; fwd_lo = PH_B; end
      default: valid_o = 1'b0;
    endcase
  end

  // reverse order: the same pair with high and low phases exchanged
  always_comb begin
    if (dir_i) begin
      drive_o.hi = fwd_hi;
      drive_o.lo = fwd_lo;
    end else begin
      drive_o.hi = fwd_lo;
      drive_o.lo = fwd_hi;
    end
  end

endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hcm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hall_a_i,
  input  logic hall_b_i,
  input  logic hall_c_i,
  input  logic dir_i,
  input  logic brake_i,
  input  logic coast_i,
  input  logic quad_sel_i,
  input  logic oc_trip_i,
  input  logic pwm_off_i,
  input  logic cyc_start_i,
  input  logic uv_i,
  output logic hi_a_o,
  output logic hi_b_o,
  output logic hi_c_o,
  output logic lo_a_o,
  output logic lo_b_o,
  output logic lo_c_o
);

  localparam int CHOP_SRCS = 2;   // bit 1: over-current, bit 0: PWM

  logic [2:0]           hall_raw;
  logic [2:0]           hall_s;
  logic [CHOP_SRCS-1:0] chop_req;
  logic [CHOP_SRCS-1:0] chop_q;
  logic                 chop_on;
  drive_t               table_drv;
  logic                 code_ok;
  drive_t               drv_d;
  drive_t               drv_q;

  assign hall_raw = {hall_a_i, hall_b_i, hall_c_i};
  assign chop_req = {oc_trip_i, pwm_off_i};

  hcm_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (hall_raw),
    .q_o   (hall_s)
  );

  hcm_cycle_latch #(
    .WIDTH (CHOP_SRCS)
  ) chop_latch_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (chop_req),
    .clr_i (cyc_start_i),
    .q_o   (chop_q)
  );

  hcm_decode decode_i (
    .code_i  (hall_s),
    .dir_i   (dir_i),
    .drive_o (table_drv),
    .valid_o (code_ok)
  );

  assign chop_on = |chop_q;

  // priority: undervoltage / coast, then brake, then normal drive
  always_comb begin
    drv_d.hi = PH_NONE;
    drv_d.lo = PH_NONE;
    if (uv_i || coast_i) begin
      drv_d.hi = PH_NONE;
      drv_d.lo = PH_NONE;
    end else if (brake_i) begin
      drv_d.hi = PH_NONE;
      drv_d.lo = chop_on ? PH_NONE : PH_ALL;
    end else if (code_ok) begin
      drv_d.lo = chop_on ? PH_NONE : table_drv.lo;
      if (quad_sel_i) begin
        drv_d.hi = chop_on ? PH_NONE : table_drv.hi;
      end else begin
        drv_d.hi = table_drv.hi;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= '0;
    end else begin
      drv_q <= drv_d;
    end
  end

  assign hi_a_o = drv_q.hi[0];
  assign hi_b_o = drv_q.hi[1];
  assign hi_c_o = drv_q.hi[2];
  assign lo_a_o = drv_q.lo[0];
  assign lo_b_o = drv_q.lo[1];
  assign lo_c_o = drv_q.lo[2];

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (({hi_c_o, hi_b_o, hi_a_o} & {lo_c_o, lo_b_o, lo_a_o}) == 3'b000)) else $error("phase leg shorted"); // R12

  AST_COAST_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    coast_i |=> ({hi_a_o, hi_b_o, hi_c_o, lo_a_o, lo_b_o, lo_c_o} == 6'b0)) else $error("coast not off"); // R4

  AST_UV_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> ({hi_a_o, hi_b_o, hi_c_o, lo_a_o, lo_b_o, lo_c_o} == 6'b0)) else $error("undervoltage not off"); // R7

  AST_BRAKE_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    brake_i |=> ({hi_a_o, hi_b_o, hi_c_o} == 3'b000)) else $error("high side on in brake"); // R5

  AST_CHOP_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    chop_on |=> ({lo_a_o, lo_b_o, lo_c_o} == 3'b000)) else $error("low side on while chopped"); // R8

  AST_SINGLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_a_o, hi_b_o, hi_c_o})) else $error("two high sides on"); // R1

  AST_SINGLE_LOW_NO_BRAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !brake_i |=> $onehot0({lo_a_o, lo_b_o, lo_c_o})) else $error("two low sides on outside brake"); // R2

endmodule

// File: tb/hall_commutator_tb_top.sv
module hall_commutator_tb_top;

  logic clk;
  logic rst_n;
  logic hall_a, hall_b, hall_c;
  logic dir, brake, coast, quad, oc, pwm, cyc, uv;
  logic hi_a, hi_b, hi_c, lo_a, lo_b, lo_c;

  int checks;
  int errors;
  bit m_chop;

  typedef struct {
    string      tag;
    logic [2:0] hi;
    logic [2:0] lo;
  } exp_t;

  exp_t sb_q[$];
  event chk_ev;

  hall_commutator dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .hall_a_i    (hall_a),
    .hall_b_i    (hall_b),
    .hall_c_i    (hall_c),
    .dir_i       (dir),
    .brake_i     (brake),
    .coast_i     (coast),
    .quad_sel_i  (quad),
    .oc_trip_i   (oc),
    .pwm_off_i   (pwm),
    .cyc_start_i (cyc),
    .uv_i        (uv),
    .hi_a_o      (hi_a),
    .hi_b_o      (hi_b),
    .hi_c_o      (hi_c),
    .lo_a_o      (lo_a),
    .lo_b_o      (lo_b),
    .lo_c_o      (lo_c)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // expected drive {hi, lo}, phase bit 0 = A, 1 = B, 2 = C
  function automatic logic [5:0] model(logic [2:0] code);
    logic [2:0] h, l, t;
    h = 3'b000;
    l = 3'b000;
    case (code)
      3'b101: begin h = 3'b001; l = 3'b010; end
      3'b100: begin h = 3'b001; l = 3'b100; end
      3'b110: begin h = 3'b010; l = 3'b100; end
      3'b010: begin h = 3'b010; l = 3'b001; end
      3'b011: begin h = 3'b100; l = 3'b001; end
      3'b001: begin h = 3'b100; l = 3'b010; end
      default: begin h = 3'b000; l = 3'b000; end
    endcase
    if (!dir) begin t = h; h = l; l = t; end
    if (uv || coast) return 6'b0;
    if (brake) return {3'b000, (m_chop ? 3'b000 : 3'b111)};
    if (m_chop) begin
      l = 3'b000;
      if (quad) h = 3'b000;
    end
    return {h, l};
  endfunction

  task automatic expect_out(string tag, logic [5:0] e);
    exp_t it;
    it.tag = tag;
    it.hi  = e[5:3];
    it.lo  = e[2:0];
    sb_q.push_back(it);
    -> chk_ev;
    #0;
  endtask

  // monitor: compares queued expectations with the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_t it;
        logic [2:0] ah, al;
        it = sb_q.pop_front();
        ah = {hi_c, hi_b, hi_a};
        al = {lo_c, lo_b, lo_a};
        checks++;
        if (ah !== it.hi || al !== it.lo) begin
          errors++;
          $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", it.tag, ah, al, it.hi, it.lo);
        end
        checks++;
        if ((ah & al) !== 3'b000) begin
          errors++;
          $display("FAIL R12: hi=%b lo=%b expected no overlap (0)", ah, al);
        end
      end
    end
  end

  task automatic set_hall(logic [2:0] code);
    {hall_a, hall_b, hall_c} = code;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_code(string tag, logic [2:0] code);
    set_hall(code);
    settle();
    expect_out(tag, model(code));
  endtask

  task automatic pulse_pwm();
    @(negedge clk); pwm = 1'b1; m_chop = 1'b1;
    @(negedge clk); pwm = 1'b0;
  endtask

  task automatic pulse_oc();
    @(negedge clk); oc = 1'b1; m_chop = 1'b1;
    @(negedge clk); oc = 1'b0;
  endtask

  task automatic pulse_cyc();
    @(negedge clk); cyc = 1'b1;
    @(negedge clk); cyc = 1'b0; m_chop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] cur;
    checks = 0; errors = 0; m_chop = 1'b0;
    rst_n = 1'b0;
    {hall_a, hall_b, hall_c} = 3'b101;
    dir = 1'b1; brake = 1'b0; coast = 1'b0; quad = 1'b0;
    oc = 1'b0; pwm = 1'b0; cyc = 1'b0; uv = 1'b0;
    repeat (3) @(negedge clk);
    expect_out("RST", 6'b0);
    rst_n = 1'b1;

    // R1 forward order
    dir = 1'b1;
    foreach (cur[i]) ;
    check_code("R1 101", 3'b101);
    check_code("R1 100", 3'b100);
    check_code("R1 110", 3'b110);
    check_code("R1 010", 3'b010);
    check_code("R1 011", 3'b011);
    check_code("R1 001", 3'b001);
    // R2 reverse order
    dir = 1'b0;
    check_code("R2 101", 3'b101);
    check_code("R2 001", 3'b001);
    check_code("R2 011", 3'b011);
    check_code("R2 010", 3'b010);
    check_code("R2 110", 3'b110);
    check_code("R2 100", 3'b100);
    // R3 invalid codes in both orders
    check_code("R3 000 rev", 3'b000);
    check_code("R3 111 rev", 3'b111);
    dir = 1'b1;
    check_code("R3 000 fwd", 3'b000);
    check_code("R3 111 fwd", 3'b111);

    // R4 coast overrides brake and a valid code
    coast = 1'b1; brake = 1'b1;
    check_code("R4 coast+brake", 3'b110);
    brake = 1'b0; quad = 1'b1;
    check_code("R4 coast drive", 3'b011);
    coast = 1'b0; quad = 1'b0;

    // R5 brake
    brake = 1'b1;
    check_code("R5 brake", 3'b010);
    // R6 brake with chopping
    pulse_pwm();
    settle();
    expect_out("R6 brake pwm", model(3'b010));
    pulse_cyc();
    settle();
    expect_out("R6 brake restored", model(3'b010));
    pulse_oc();
    settle();
    expect_out("R6 brake oc", model(3'b010));
    pulse_cyc();
    settle();
    brake = 1'b0;

    // R7 undervoltage
    uv = 1'b1;
    check_code("R7 uv drive", 3'b100);
    brake = 1'b1;
    check_code("R7 uv brake", 3'b100);
    uv = 1'b0; brake = 1'b0;

    // R8 two-quadrant chopping
    quad = 1'b0;
    check_code("R8 base", 3'b011);
    pulse_pwm();
    settle();
    expect_out("R8 pwm chop", model(3'b011));
    // R10 latch holds for many cycles
    repeat (10) @(posedge clk);
    @(negedge clk);
    expect_out("R10 held", model(3'b011));
    pulse_cyc();
    settle();
    expect_out("R10 cleared", model(3'b011));

    // R9 four-quadrant chopping
    quad = 1'b1; dir = 1'b0;
    check_code("R9 base", 3'b001);
    pulse_oc();
    settle();
    expect_out("R9 oc chop", model(3'b001));
    pulse_cyc();
    settle();
    expect_out("R9 cleared", model(3'b001));

    // R10 request together with cycle start keeps latch set
    @(negedge clk); pwm = 1'b1; cyc = 1'b1; m_chop = 1'b1;
    @(negedge clk); pwm = 1'b0; cyc = 1'b0;
    settle();
    expect_out("R10 set wins", model(3'b001));
    pulse_cyc();
    settle();

    // R11 sensor path latency: third edge
    quad = 1'b0; dir = 1'b1;
    check_code("R11 start", 3'b101);
    set_hall(3'b100);
    repeat (2) @(posedge clk);
    @(negedge clk);
    expect_out("R11 hall edge2 old", model(3'b101));
    @(posedge clk);
    @(negedge clk);
    expect_out("R11 hall edge3 new", model(3'b100));
    // R11 control path latency: first edge
    coast = 1'b1;
    @(posedge clk);
    @(negedge clk);
    expect_out("R11 coast edge1", 6'b0);
    coast = 1'b0;
    settle();
    // R11 chop path latency: second edge
    pwm = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pwm = 1'b0;
    expect_out("R11 chop edge1 still on", model(3'b100));
    m_chop = 1'b1;
    @(posedge clk);
    @(negedge clk);
    expect_out("R11 chop edge2 off", model(3'b100));
    pulse_cyc();
    settle();

    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule